// File: doc/BRIEF.md
# BCD Seven-Segment Decoder with Ripple Blanking

This block converts a four-bit decimal digit into seven active-high drives for segments a to g. Two control inputs set the display mode. `disp_en` chooses between normal decoding and a set of override modes. `ripple_in` is an active-low zero-suppression request from the stage on the more significant side. The block returns `ripple_out` to the next stage. When several copies are chained through this signal, leading zeros are blanked until the first non-zero digit. The same two controls also give a lamp test that lights every segment, and a forced blank that can be pulsed to dim the display.

Decoding is combinational. When the `REG_OUT` parameter is set (the default), one output register sits after the decoder, so the segments and `ripple_out` follow the inputs one clock later. The codes 10 to 15 are not decimal digits, and they always leave the display dark.

Top module: `bcd_seg_decoder`

## Requirements
- R1: With `disp_en`=0 and `ripple_in`=0, all seven segments are lit (`segs`=7'h7F) and `ripple_out`=0, whatever the code.
- R2: With `disp_en`=0 and `ripple_in`=1, all segments are dark (`segs`=0) and `ripple_out`=1, whatever the code.
- R3: With `disp_en`=1, `ripple_in`=1 and code 0, the zero pattern a..f is shown (`segs`=7'h7E) and `ripple_out`=1.
- R4: With `disp_en`=1, `ripple_in`=0 and code 0, the digit is suppressed (`segs`=0) and `ripple_out`=0, which passes suppression to the next stage.
- R5: With `disp_en`=1, codes 1 to 9 are shown whatever `ripple_in` is, and `ripple_out`=1. The bus order is {a,b,c,d,e,f,g} from bit 6 down to bit 0. The patterns are 1=7'h30, 2=7'h6D, 3=7'h79, 4=7'h33, 5=7'h5B, 7=7'h70 and 8=7'h7F.
- R6: Digit 6 is drawn without segment a (`segs`=7'h1F). Digit 9 is drawn without segment d (`segs`=7'h73).
- R7: With `disp_en`=1, codes 10 to 15 blank all segments and drive `ripple_out`=1, so an invalid code never passes suppression on.
- R8: With `REG_OUT`=1, the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low they hold `segs`=0 and `ripple_out`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_en | input | 1 | Display enable; 0 selects lamp test or forced blank |
| ripple_in | input | 1 | Active-low zero-suppression request from the preceding stage |
| bcd | input | 4 | Digit code |
| segs | output | 7 | Segment drives {a,b,c,d,e,f,g}, active high |
| ripple_out | output | 1 | Active-low zero-suppression request to the following stage |

## Verification
The bench drives all 64 combinations of enable, ripple input and code, then a pseudo-random sequence that changes the inputs on every cycle. The random sequence catches a pipeline that holds stale values or mixes up cycles. The zero code is the sharpest corner. If the ripple input is ignored there, zeros show through where they should be suppressed. If `ripple_out` is inverted there, suppression stops too early or runs past the first significant digit. The 6 and 9 patterns would show an extra segment if tailed glyphs were used. Codes 10 to 15 with enable high would either light a pattern or pull `ripple_out` low and blank the next digit.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
  localparam int SEG_W = 7;
  localparam int DIG_W = 4;
  localparam int MAX_DIGIT = 9;

  typedef logic [SEG_W-1:0] seg_t;

  localparam seg_t SEG_ALL  = '1;
  localparam seg_t SEG_NONE = '0;

  typedef enum logic [2:0] {
    MODE_LAMP,
    MODE_BLANK,
    MODE_ZERO,
    MODE_SUPP,
    MODE_DIGIT,
    MODE_INVALID
  } disp_mode_e;
endpackage

// File: rtl/bcd_seg_rom.sv
module bcd_seg_rom
  import bcd_seg_pkg::*;
(
  input  logic [DIG_W-1:0] code,
  output seg_t             pattern,
  output logic             valid,
  output logic             is_zero
);
  always_comb begin
    unique case (code)
      4'd0:    pattern = 7'b1111110;
      4'd1:    pattern = 7'b0110000;
      4'd2:    pattern = 7'b1101101;
      4'd3:    pattern = 7'b1111001;
      4'd4:    pattern = 7'b0110011;
      4'd5:    pattern = 7'b1011011;
      4'd6:    pattern = 7'b0011111;
      4'd7:    pattern = 7'b1110000;
      4'd8:    pattern = 7'b1111111;
      4'd9:    pattern = 7'b1110011;
      default: pattern = SEG_NONE;
    endcase
  end

  assign valid   = (code <= DIG_W'(MAX_DIGIT));
  assign is_zero = (code == '0);
endmodule

// File: rtl/bcd_seg_mode.sv
module bcd_seg_mode
  import bcd_seg_pkg::*;
(
  input  logic       disp_en,
  input  logic       ripple_in,
  input  logic       valid,
  input  logic       is_zero,
  output disp_mode_e mode
);
  always_comb begin
    if (!disp_en) begin
      mode = ripple_in ? MODE_BLANK : MODE_LAMP;
    end else if (!valid) begin
      mode = MODE_INVALID;
    end else if (is_zero) begin
      mode = ripple_in ? MODE_ZERO : MODE_SUPP;
    end else begin
      mode = MODE_DIGIT;
    end
  end
endmodule

// File: rtl/bcd_seg_outreg.sv
module bcd_seg_outreg #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= RST_VAL;
        else        q_r <= d;
      end
      assign q = q_r;
    end else begin : g_pass
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/bcd_seg_decoder.sv
module bcd_seg_decoder
  import bcd_seg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             disp_en,
  input  logic             ripple_in,
  input  logic [DIG_W-1:0] bcd,
  output logic [SEG_W-1:0] segs,
  output logic             ripple_out
);
  localparam int OUT_W = SEG_W + 1;
  localparam logic [OUT_W-1:0] OUT_RST = {SEG_NONE, 1'b1};

  seg_t       rom_pat;
  logic       rom_valid;
  logic       rom_zero;
  disp_mode_e mode;
  seg_t       segs_nx;
  logic       rout_nx;
  logic [OUT_W-1:0] out_q;

  bcd_seg_rom u_rom (
    .code    (bcd),
    .pattern (rom_pat),
    .valid   (rom_valid),
    .is_zero (rom_zero)
  );

  bcd_seg_mode u_mode (
    .disp_en   (disp_en),
    .ripple_in (ripple_in),
    .valid     (rom_valid),
    .is_zero   (rom_zero),
    .mode      (mode)
  );

  // next-value selection
  always_comb begin
    segs_nx = SEG_NONE;
    rout_nx = 1'b1;
    unique case (mode)
      MODE_LAMP:    begin segs_nx = SEG_ALL;  rout_nx = 1'b0; end
      MODE_BLANK:   begin segs_nx = SEG_NONE; rout_nx = 1'b1; end
      MODE_ZERO:    begin segs_nx = rom_pat;  rout_nx = 1'b1; end
      MODE_SUPP:    begin segs_nx = SEG_NONE; rout_nx = 1'b0; end
      MODE_DIGIT:   begin segs_nx = rom_pat;  rout_nx = 1'b1; end
      MODE_INVALID: begin segs_nx = SEG_NONE; rout_nx = 1'b1; end
      default:      begin segs_nx = SEG_NONE; rout_nx = 1'b1; end
    endcase
  end

  bcd_seg_outreg #(
    .W       (OUT_W),
    .REG_OUT (REG_OUT),
    .RST_VAL (OUT_RST)
  ) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({segs_nx, rout_nx}),
    .q     (out_q)
  );

  assign segs       = out_q[OUT_W-1:1];
  assign ripple_out = out_q[0];
endmodule

// File: rtl/bcd_seg_decoder_chk.sv
module bcd_seg_decoder_chk
  import bcd_seg_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             disp_en,
  input logic             ripple_in,
  input logic [DIG_W-1:0] bcd,
  input logic [SEG_W-1:0] segs,
  input logic             ripple_out
);
  logic armed;
  logic o_en, o_rin;
  logic [DIG_W-1:0] o_bcd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  generate
    if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          o_en  <= 1'b0;
          o_rin <= 1'b1;
          o_bcd <= '0;
        end else begin
          o_en  <= disp_en;
          o_rin <= ripple_in;
          o_bcd <= bcd;
        end
      end
    end else begin : g_live
      assign o_en  = disp_en;
      assign o_rin = ripple_in;
      assign o_bcd = bcd;
    end
  endgenerate

  // R1
  lamp_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !o_en && !o_rin) |-> (segs == 7'h7F && !ripple_out));

  // R2
  forced_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !o_en && o_rin) |-> (segs == 7'h00 && ripple_out));

  // R3
  zero_shown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && o_en && o_rin && o_bcd == 4'd0) |-> (segs == 7'h7E && ripple_out));

  // R4
  zero_supp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && o_en && !o_rin && o_bcd == 4'd0) |-> (segs == 7'h00 && !ripple_out));

  // R5
  digit_lit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && o_en && o_bcd >= 4'd1 && o_bcd <= 4'd9) |-> (segs != 7'h00 && ripple_out));

  // R6
  six_no_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && o_en && o_bcd == 4'd6) |-> (!segs[6] && segs[2]));

  // R6
  nine_no_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && o_en && o_bcd == 4'd9) |-> (!segs[3] && segs[6]));

  // R7
  invalid_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && o_en && o_bcd > 4'd9) |-> (segs == 7'h00 && ripple_out));
endmodule

bind bcd_seg_decoder bcd_seg_decoder_chk #(.REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .disp_en    (disp_en),
  .ripple_in  (ripple_in),
  .bcd        (bcd),
  .segs       (segs),
  .ripple_out (ripple_out)
);

// File: tb/bcd_seg_decoder_bench.sv
module bcd_seg_decoder_bench;
  logic       clk;
  logic       rst_n;
  logic       disp_en;
  logic       ripple_in;
  logic [3:0] bcd;
  logic [6:0] segs;
  logic       ripple_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [6:0] seg;
    logic       rout;
    string      req;
  } exp_t;

  exp_t q[$];

  bcd_seg_decoder u_bcd_seg_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .disp_en    (disp_en),
    .ripple_in  (ripple_in),
    .bcd        (bcd),
    .segs       (segs),
    .ripple_out (ripple_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [6:0] glyph(input int d);
    // {a,b,c,d,e,f,g}
    case (d)
      0: return 7'h7E;
      1: return 7'h30;
      2: return 7'h6D;
      3: return 7'h79;
      4: return 7'h33;
      5: return 7'h5B;
      6: return 7'h1F;
      7: return 7'h70;
      8: return 7'h7F;
      9: return 7'h73;
      default: return 7'h00;
    endcase
  endfunction

  function automatic exp_t model(input logic en, input logic rin, input int code);
    exp_t e;
    if (!en && !rin)      begin e.seg = 7'h7F; e.rout = 1'b0; e.req = "R1"; end
    else if (!en)         begin e.seg = 7'h00; e.rout = 1'b1; e.req = "R2"; end
    else if (code > 9)    begin e.seg = 7'h00; e.rout = 1'b1; e.req = "R7"; end
    else if (code == 0 && rin)  begin e.seg = 7'h7E; e.rout = 1'b1; e.req = "R3"; end
    else if (code == 0)   begin e.seg = 7'h00; e.rout = 1'b0; e.req = "R4"; end
    else begin
      e.seg = glyph(code); e.rout = 1'b1;
      e.req = (code == 6 || code == 9) ? "R6" : "R5";
    end
    return e;
  endfunction

  // driver: change inputs at the falling edge, queue the expectation
  task automatic apply(input logic en, input logic rin, input int code);
    @(negedge clk);
    disp_en   = en;
    ripple_in = rin;
    bcd       = 4'(code);
    q.push_back(model(en, rin, code));
  endtask

  // monitor: result is registered at the next rising edge (R8)
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_checks++;
        if (segs !== e.seg || ripple_out !== e.rout) begin
          n_fail++;
          $display("FAIL %s (R8 timing): actual segs=%h rout=%b expected segs=%h rout=%b",
                   e.req, segs, ripple_out, e.seg, e.rout);
        end
      end
    end
  end

  initial begin
    rst_n     = 1'b0;
    disp_en   = 1'b1;
    ripple_in = 1'b0;
    bcd       = 4'd8;
    repeat (3) @(posedge clk);
    #5;
    // R8 reset state
    n_checks++;
    if (segs !== 7'h00 || ripple_out !== 1'b1) begin
      n_fail++;
      $display("FAIL R8 reset: actual segs=%h rout=%b expected segs=00 rout=1",
               segs, ripple_out);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // exhaustive sweep: R1 R2 R3 R4 R5 R6 R7
    for (int en = 0; en < 2; en++)
      for (int rin = 0; rin < 2; rin++)
        for (int c = 0; c < 16; c++)
          apply(en[0], rin[0], c);

    // back-to-back pseudo-random stimulus (R8 latency)
    for (int i = 0; i < 200; i++) begin
      int r;
      r = int'($urandom_range(0, 63));
      apply(r[5], r[4], r & 15);
    end

    @(negedge clk);
    @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule